// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes instruction bytes one at a time from an instruction fetch port and rebuilds each instruction into a single decoded record. The head byte carries a 4-bit operation code and a 4-bit argument-format code. The format code fixes the kind and order of the operands that follow: register, 32-bit immediate or memory pointer. A pointer operand carries a size mode, a base register, a 32-bit address and a signed 16-bit offset. Instructions are 1 to 12 bytes long, and the record reports the number of bytes consumed so the fetch logic can advance its instruction pointer.

The input is a byte stream with a valid/ready handshake. The output record also uses valid/ready and is held until it is taken. An encoding that cannot be executed produces no record. It raises a one-cycle illegal pulse together with the number of bytes that were consumed for it.

Top module: `vld_decoder`

## Requirements
- R1: The low nibble of the head byte is reported as `out_opcode` and the high nibble as `out_fmt`.
- R2: The instruction length, reported on `out_len`, is 1 plus the sizes of its operands. A register operand is 1 byte, an immediate is 4 bytes and a pointer is 7 bytes. This gives format 0 = 12, 1 = 9, 2 = 6, 3 = 9, 4 = 3, 5 = 9 and 6 = 5 bytes, and exactly that many bytes are accepted.
- R3: The accepted operation/format pairs are:
  - opcode 0 with formats 0 to 4;
  - opcodes 1 to 9 with formats 2 and 4;
  - opcode 0xA with formats 2, 4 and 5;
  - opcodes 0xB and 0xD with format 6;
  - opcode 0xC with format 3.

  Any other head byte is consumed alone. It produces `bad_valid` for one cycle, starting the cycle after it was accepted, with `bad_len` = 1 and no record. The next byte is then treated as a new head.
- R4: A pointer operand is laid out as follows. Its first byte holds the size mode in the low nibble and the base register in the high nibble. A 4-byte little-endian address follows, then a 2-byte little-endian signed offset. The pointer starts at byte 1 in formats 0 and 1 and at byte 2 in format 3.
- R5: A pointer size mode above 5 does not stop the instruction from being accepted in full. It produces `bad_valid` with `bad_len` equal to the full instruction length and no record.
- R6: `out_ptr_reg` carries the base register field for size modes 3 to 5 and reads zero for direct modes 0 to 2.
- R7: A register operand is one byte with the index in its low nibble; its high nibble is ignored. The first register operand goes to `out_reg_a` and a second one goes to `out_reg_b`.
- R8: Immediates are 4 bytes, little-endian. The first immediate operand goes to `out_imm_a` and a second one goes to `out_imm_b`.
- R9: Record fields that the instruction's format does not use read zero.
- R10: `out_valid` rises the cycle after the last byte is accepted. While `out_valid` is high and `out_ready` is low, the record holds steady and `in_ready` stays low. The cycle after `out_ready` is seen, `in_ready` is high again.
- R11: After reset, `in_ready` is 1 and both `out_valid` and `bad_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 4 | Operation code |
| out_fmt | output | 4 | Argument-format code |
| out_reg_a | output | 4 | First register operand |
| out_reg_b | output | 4 | Second register operand |
| out_imm_a | output | 32 | First immediate |
| out_imm_b | output | 32 | Second immediate |
| out_ptr_size | output | 4 | Pointer size mode |
| out_ptr_reg | output | 4 | Pointer base register |
| out_ptr_addr | output | 32 | Pointer address |
| out_ptr_off | output | 16 | Pointer signed offset |
| out_len | output | 4 | Instruction length in bytes |
| bad_valid | output | 1 | Illegal encoding pulse |
| bad_len | output | 4 | Bytes consumed by the illegal encoding |

## Verification
Every result is one register stage behind the byte that completes it. The record and the illegal pulse both appear in the cycle after the edge that accepts the final byte, or the head byte for a bad pair. The bench therefore checks them 1 time unit after that accepting edge. One cycle later it confirms that the pulse has dropped. It also confirms, after the next-to-last byte, that no record is shown early. For backpressure, the bench samples the held record over several cycles at the same offset from the edge. It then checks `in_ready` on the cycle after the record is taken.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int WORD_W     = 32;
    localparam int OFF_W      = 16;
    localparam int IMM_BYTES  = WORD_W / BYTE_W;
    localparam int ADDR_BYTES = WORD_W / BYTE_W;
    localparam int OFF_BYTES  = OFF_W / BYTE_W;
    localparam int PTR_BYTES  = 1 + ADDR_BYTES + OFF_BYTES;
    localparam int MAX_LEN    = 1 + PTR_BYTES + IMM_BYTES;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int IDX_W      = $clog2(MAX_LEN + PTR_BYTES + 1);
    localparam int N_SLOTS    = 2;

    localparam logic [NIB_W-1:0] PTR_MODE_MAX = 4'd5;
    localparam logic [NIB_W-1:0] PTR_REG_MIN  = 4'd3;

    localparam logic [NIB_W-1:0] FMT_PTR_IMM = 4'd0;
    localparam logic [NIB_W-1:0] FMT_PTR_REG = 4'd1;
    localparam logic [NIB_W-1:0] FMT_REG_IMM = 4'd2;
    localparam logic [NIB_W-1:0] FMT_REG_PTR = 4'd3;
    localparam logic [NIB_W-1:0] FMT_REG_REG = 4'd4;
    localparam logic [NIB_W-1:0] FMT_IMM_IMM = 4'd5;
    localparam logic [NIB_W-1:0] FMT_IMM     = 4'd6;

    localparam logic [NIB_W-1:0] OP_MOVE      = 4'h0;
    localparam logic [NIB_W-1:0] OP_ALU_FIRST = 4'h1;
    localparam logic [NIB_W-1:0] OP_ALU_LAST  = 4'h9;
    localparam logic [NIB_W-1:0] OP_COMPARE   = 4'hA;
    localparam logic [NIB_W-1:0] OP_BRANCH    = 4'hB;
    localparam logic [NIB_W-1:0] OP_ADDR      = 4'hC;
    localparam logic [NIB_W-1:0] OP_TRAP      = 4'hD;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_REG,
        OPK_IMM,
        OPK_PTR
    } opk_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HOLD
    } dec_st_e;

    typedef logic [MAX_LEN-1:0][BYTE_W-1:0] ibuf_t;

    typedef struct packed {
        logic [NIB_W-1:0]  opcode;
        logic [NIB_W-1:0]  fmt;
        logic [NIB_W-1:0]  reg_a;
        logic [NIB_W-1:0]  reg_b;
        logic [WORD_W-1:0] imm_a;
        logic [WORD_W-1:0] imm_b;
        logic [NIB_W-1:0]  ptr_size;
        logic [NIB_W-1:0]  ptr_reg;
        logic [WORD_W-1:0] ptr_addr;
        logic [OFF_W-1:0]  ptr_off;
        logic [LEN_W-1:0]  len;
    } dec_rec_t;

    typedef struct packed {
        dec_st_e          st;
        ibuf_t            bytes;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] total;
        logic [IDX_W-1:0] ptr_pos;
        logic             ptr_bad;
        logic             bad;
        logic [LEN_W-1:0] bad_len;
    } dec_state_t;

    function automatic opk_e fmt_kind_first(input logic [NIB_W-1:0] f);
        opk_e k;
        case (f)
            FMT_PTR_IMM, FMT_PTR_REG:              k = OPK_PTR;
            FMT_REG_IMM, FMT_REG_PTR, FMT_REG_REG: k = OPK_REG;
            FMT_IMM_IMM, FMT_IMM:                  k = OPK_IMM;
            default:                               k = OPK_NONE;
        endcase
        return k;
    endfunction

    function automatic opk_e fmt_kind_second(input logic [NIB_W-1:0] f);
        opk_e k;
        case (f)
            FMT_PTR_IMM, FMT_REG_IMM, FMT_IMM_IMM: k = OPK_IMM;
            FMT_PTR_REG, FMT_REG_REG:              k = OPK_REG;
            FMT_REG_PTR:                           k = OPK_PTR;
            default:                               k = OPK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [IDX_W-1:0] kind_bytes(input opk_e k);
        logic [IDX_W-1:0] n;
        case (k)
            OPK_REG: n = IDX_W'(1);
            OPK_IMM: n = IDX_W'(IMM_BYTES);
            OPK_PTR: n = IDX_W'(PTR_BYTES);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vld_format_rules.sv
module vld_format_rules
    import vld_pkg::*;
(
    input  logic [BYTE_W-1:0] head_i,
    output logic              legal_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [IDX_W-1:0]  ptr_pos_o
);

    logic [NIB_W-1:0] opc;
    logic [NIB_W-1:0] fmt;
    opk_e             kind_a;
    opk_e             kind_b;
    logic [IDX_W-1:0] size_a;
    logic [IDX_W-1:0] size_b;
    logic [IDX_W-1:0] total;

    assign opc = head_i[NIB_W-1:0];
    assign fmt = head_i[BYTE_W-1:NIB_W];

    always_comb begin
        if (opc == OP_MOVE) begin
            legal_o = (fmt <= FMT_REG_REG);
        end else if (opc >= OP_ALU_FIRST && opc <= OP_ALU_LAST) begin
            legal_o = (fmt == FMT_REG_IMM) || (fmt == FMT_REG_REG);
        end else if (opc == OP_COMPARE) begin
            legal_o = (fmt == FMT_REG_IMM) || (fmt == FMT_REG_REG) || (fmt == FMT_IMM_IMM);
        end else if (opc == OP_BRANCH || opc == OP_TRAP) begin
            legal_o = (fmt == FMT_IMM);
        end else if (opc == OP_ADDR) begin
            legal_o = (fmt == FMT_REG_PTR);
        end else begin
            legal_o = 1'b0;
        end
    end

    always_comb begin
        kind_a = fmt_kind_first(fmt);
        kind_b = fmt_kind_second(fmt);
        size_a = kind_bytes(kind_a);
        size_b = kind_bytes(kind_b);
        total  = IDX_W'(1) + size_a + size_b;
        len_o  = LEN_W'(total);
        if (kind_a == OPK_PTR) begin
            ptr_pos_o = IDX_W'(1);
        end else if (kind_b == OPK_PTR) begin
            ptr_pos_o = IDX_W'(1) + size_a;
        end else begin
            ptr_pos_o = '0;
        end
    end

endmodule

// File: rtl/vld_field_extract.sv
module vld_field_extract
    import vld_pkg::*;
(
    input  ibuf_t    buf_i,
    output dec_rec_t rec_o
);

    function automatic logic [BYTE_W-1:0] pick(input ibuf_t b, input logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (IDX_W'(i) == idx) begin
                r = b[i];
            end
        end
        return r;
    endfunction

    logic [NIB_W-1:0] fmt;
    opk_e             kind [N_SLOTS];
    logic [IDX_W-1:0] pos  [N_SLOTS];

    logic [NIB_W-1:0]  s_reg   [N_SLOTS];
    logic [WORD_W-1:0] s_imm   [N_SLOTS];
    logic [NIB_W-1:0]  s_psize [N_SLOTS];
    logic [NIB_W-1:0]  s_preg  [N_SLOTS];
    logic [WORD_W-1:0] s_paddr [N_SLOTS];
    logic [OFF_W-1:0]  s_poff  [N_SLOTS];

    assign fmt = buf_i[0][BYTE_W-1:NIB_W];

    always_comb begin
        kind[0] = fmt_kind_first(fmt);
        kind[1] = fmt_kind_second(fmt);
        pos[0]  = IDX_W'(1);
        pos[1]  = IDX_W'(1) + kind_bytes(kind[0]);
    end

    // One slicer per operand slot; each reads every field shape at its start byte.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic [BYTE_W-1:0] lead;
        always_comb begin
            lead       = pick(buf_i, pos[s]);
            s_reg[s]   = lead[NIB_W-1:0];
            s_psize[s] = lead[NIB_W-1:0];
            s_preg[s]  = lead[BYTE_W-1:NIB_W];
            for (int k = 0; k < IMM_BYTES; k++) begin
                s_imm[s][k*BYTE_W +: BYTE_W] = pick(buf_i, pos[s] + IDX_W'(k));
            end
            for (int k = 0; k < ADDR_BYTES; k++) begin
                s_paddr[s][k*BYTE_W +: BYTE_W] = pick(buf_i, pos[s] + IDX_W'(1 + k));
            end
            for (int k = 0; k < OFF_BYTES; k++) begin
                s_poff[s][k*BYTE_W +: BYTE_W] = pick(buf_i, pos[s] + IDX_W'(1 + ADDR_BYTES + k));
            end
        end
    end

    always_comb begin
        rec_o        = '0;
        rec_o.opcode = buf_i[0][NIB_W-1:0];
        rec_o.fmt    = fmt;
        rec_o.len    = LEN_W'(IDX_W'(1) + kind_bytes(kind[0]) + kind_bytes(kind[1]));

        if (kind[0] == OPK_REG) begin
            rec_o.reg_a = s_reg[0];
            if (kind[1] == OPK_REG) begin
                rec_o.reg_b = s_reg[1];
            end
        end else if (kind[1] == OPK_REG) begin
            rec_o.reg_a = s_reg[1];
        end

        if (kind[0] == OPK_IMM) begin
            rec_o.imm_a = s_imm[0];
            if (kind[1] == OPK_IMM) begin
                rec_o.imm_b = s_imm[1];
            end
        end else if (kind[1] == OPK_IMM) begin
            rec_o.imm_a = s_imm[1];
        end

        for (int s = 0; s < N_SLOTS; s++) begin
            if (kind[s] == OPK_PTR) begin
                rec_o.ptr_size = s_psize[s];
                rec_o.ptr_reg  = (s_psize[s] >= PTR_REG_MIN) ? s_preg[s] : '0;
                rec_o.ptr_addr = s_paddr[s];
                rec_o.ptr_off  = s_poff[s];
            end
        end
    end

endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
    import vld_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_byte,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [NIB_W-1:0]   out_opcode,
    output logic [NIB_W-1:0]   out_fmt,
    output logic [NIB_W-1:0]   out_reg_a,
    output logic [NIB_W-1:0]   out_reg_b,
    output logic [WORD_W-1:0]  out_imm_a,
    output logic [WORD_W-1:0]  out_imm_b,
    output logic [NIB_W-1:0]   out_ptr_size,
    output logic [NIB_W-1:0]   out_ptr_reg,
    output logic [WORD_W-1:0]  out_ptr_addr,
    output logic [OFF_W-1:0]   out_ptr_off,
    output logic [LEN_W-1:0]   out_len,
    output logic               bad_valid,
    output logic [LEN_W-1:0]   bad_len
);

    dec_state_t       st_q;
    dec_state_t       st_d;
    dec_rec_t         rec;
    logic             head_legal;
    logic [LEN_W-1:0] head_len;
    logic [IDX_W-1:0] head_ptr_pos;
    logic             take;
    logic             ptr_hit_bad;

    vld_format_rules u_rules (
        .head_i    (in_byte),
        .legal_o   (head_legal),
        .len_o     (head_len),
        .ptr_pos_o (head_ptr_pos)
    );

    vld_field_extract u_extract (
        .buf_i (st_q.bytes),
        .rec_o (rec)
    );

    assign in_ready = (st_q.st != ST_HOLD);
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d        = st_q;
        st_d.bad    = 1'b0;
        ptr_hit_bad = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (take) begin
                    st_d.bytes    = '0;
                    st_d.bytes[0] = in_byte;
                    if (!head_legal) begin
                        st_d.bad     = 1'b1;
                        st_d.bad_len = LEN_W'(1);
                    end else begin
                        st_d.st      = ST_COLLECT;
                        st_d.cnt     = LEN_W'(1);
                        st_d.total   = head_len;
                        st_d.ptr_pos = head_ptr_pos;
                        st_d.ptr_bad = 1'b0;
                    end
                end
            end
            ST_COLLECT: begin
                if (take) begin
                    for (int i = 1; i < MAX_LEN; i++) begin
                        if (LEN_W'(i) == st_q.cnt) begin
                            st_d.bytes[i] = in_byte;
                        end
                    end
                    ptr_hit_bad  = (st_q.ptr_pos != '0) &&
                                   (IDX_W'(st_q.cnt) == st_q.ptr_pos) &&
                                   (in_byte[NIB_W-1:0] > PTR_MODE_MAX);
                    st_d.ptr_bad = st_q.ptr_bad || ptr_hit_bad;
                    st_d.cnt     = st_q.cnt + LEN_W'(1);
                    if (st_q.cnt == st_q.total - LEN_W'(1)) begin
                        if (st_d.ptr_bad) begin
                            st_d.bad     = 1'b1;
                            st_d.bad_len = st_q.total;
                            st_d.st      = ST_IDLE;
                        end else begin
                            st_d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    st_d.st = ST_IDLE;
                end
            end
            default: begin
                st_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = (st_q.st == ST_HOLD);
    assign out_opcode   = rec.opcode;
    assign out_fmt      = rec.fmt;
    assign out_reg_a    = rec.reg_a;
    assign out_reg_b    = rec.reg_b;
    assign out_imm_a    = rec.imm_a;
    assign out_imm_b    = rec.imm_b;
    assign out_ptr_size = rec.ptr_size;
    assign out_ptr_reg  = rec.ptr_reg;
    assign out_ptr_addr = rec.ptr_addr;
    assign out_ptr_off  = rec.ptr_off;
    assign out_len      = rec.len;
    assign bad_valid    = st_q.bad;
    assign bad_len      = st_q.bad_len;

endmodule

// File: rtl/vld_decoder_chk.sv
module vld_decoder_chk
    import vld_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [BYTE_W-1:0]  in_byte,
    input logic               out_valid,
    input logic               out_ready,
    input logic [NIB_W-1:0]   out_opcode,
    input logic [NIB_W-1:0]   out_fmt,
    input logic [NIB_W-1:0]   out_reg_a,
    input logic [NIB_W-1:0]   out_reg_b,
    input logic [WORD_W-1:0]  out_imm_a,
    input logic [WORD_W-1:0]  out_imm_b,
    input logic [NIB_W-1:0]   out_ptr_size,
    input logic [NIB_W-1:0]   out_ptr_reg,
    input logic [WORD_W-1:0]  out_ptr_addr,
    input logic [OFF_W-1:0]   out_ptr_off,
    input logic [LEN_W-1:0]   out_len,
    input logic               bad_valid,
    input logic [LEN_W-1:0]   bad_len
);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_fmt) &&
            $stable(out_imm_a) && $stable(out_imm_b) && $stable(out_ptr_addr) &&
            $stable(out_ptr_off) && $stable(out_reg_a) && $stable(out_len)));

    assert_no_input_while_holding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_rise_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_bad_excludes_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_valid |-> !out_valid);

    assert_bad_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_valid |-> (bad_len != '0) && (bad_len <= LEN_W'(MAX_LEN)));

    assert_ptr_mode_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ptr_size <= PTR_MODE_MAX));

    assert_direct_base_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ptr_size < PTR_REG_MIN) |-> (out_ptr_reg == '0));

    assert_len_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == 4'd3 || out_len == 4'd5 || out_len == 4'd6 ||
                       out_len == 4'd9 || out_len == 4'd12));

endmodule

bind vld_decoder vld_decoder_chk u_chk (.*);

// File: tb/vld_decoder_tb.sv
module vld_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_opcode, out_fmt, out_reg_a, out_reg_b;
    logic [31:0] out_imm_a, out_imm_b;
    logic [3:0]  out_ptr_size, out_ptr_reg;
    logic [31:0] out_ptr_addr;
    logic [15:0] out_ptr_off;
    logic [3:0]  out_len;
    logic        bad_valid;
    logic [3:0]  bad_len;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ib [12];
    int ilen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vld_decoder u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        ilen = 0;
    endtask

    task automatic put(input logic [7:0] b);
        ib[ilen] = b;
        ilen++;
    endtask

    task automatic put_imm(input logic [31:0] v);
        for (int k = 0; k < 4; k++) put(v[k*8 +: 8]);
    endtask

    task automatic put_ptr(input logic [3:0] sz, input logic [3:0] rg,
                           input logic [31:0] addr, input logic [15:0] off);
        put({rg, sz});
        put_imm(addr);
        put(off[7:0]);
        put(off[15:8]);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send(input string tag);
        for (int i = 0; i < ilen; i++) begin
            push(ib[i]);
            if (i == ilen - 2) chk({tag, " R10 no early record"}, 32'(out_valid), 32'd0);
        end
    endtask

    task automatic pop();
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
    endtask

    task automatic expect_rec(input string tag, input logic [3:0] op, input logic [3:0] fm,
                              input logic [3:0] ra, input logic [3:0] rb,
                              input logic [31:0] ia, input logic [31:0] ibv,
                              input logic [3:0] psz, input logic [3:0] prg,
                              input logic [31:0] pad, input logic [15:0] pof,
                              input logic [3:0] len);
        chk({tag, " R10 out_valid"},  32'(out_valid), 32'd1);
        chk({tag, " R1 opcode"},      32'(out_opcode), 32'(op));
        chk({tag, " R1 fmt"},         32'(out_fmt), 32'(fm));
        chk({tag, " R7 reg_a"},       32'(out_reg_a), 32'(ra));
        chk({tag, " R7 reg_b"},       32'(out_reg_b), 32'(rb));
        chk({tag, " R8 imm_a"},       out_imm_a, ia);
        chk({tag, " R8 imm_b"},       out_imm_b, ibv);
        chk({tag, " R4 ptr_size"},    32'(out_ptr_size), 32'(psz));
        chk({tag, " R6 ptr_reg"},     32'(out_ptr_reg), 32'(prg));
        chk({tag, " R4 ptr_addr"},    out_ptr_addr, pad);
        chk({tag, " R4 ptr_off"},     32'(out_ptr_off), 32'(pof));
        chk({tag, " R2 len"},         32'(out_len), 32'(len));
        chk({tag, " R3 no bad"},      32'(bad_valid), 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 in_ready", 32'(in_ready), 32'd1);
        chk("R11 out_valid", 32'(out_valid), 32'd0);
        chk("R11 bad_valid", 32'(bad_valid), 32'd0);
    endtask

    task automatic t_reg_reg();
        clr(); put(8'h40); put(8'h3A); put(8'hF5);
        send("reg,reg");
        expect_rec("reg,reg R9", 4'h0, 4'h4, 4'hA, 4'h5, 0, 0, 0, 0, 0, 0, 4'd3);
        pop();
    endtask

    task automatic t_reg_imm();
        clr(); put(8'h21); put(8'h07); put_imm(32'hDEADBEEF);
        send("reg,imm");
        expect_rec("reg,imm R8", 4'h1, 4'h2, 4'h7, 4'h0, 32'hDEADBEEF, 0, 0, 0, 0, 0, 4'd6);
        pop();
    endtask

    task automatic t_imm_imm();
        clr(); put(8'h5A); put_imm(32'h12345678); put_imm(32'h80000001);
        send("imm,imm");
        expect_rec("imm,imm R8", 4'hA, 4'h5, 0, 0, 32'h12345678, 32'h80000001, 0, 0, 0, 0, 4'd9);
        pop();
    endtask

    task automatic t_imm_only();
        clr(); put(8'h6B); put_imm(32'h00000400);
        send("imm");
        expect_rec("imm R2", 4'hB, 4'h6, 0, 0, 32'h00000400, 0, 0, 0, 0, 0, 4'd5);
        pop();
    endtask

    task automatic t_ptr_imm();
        clr(); put(8'h00); put_ptr(4'd5, 4'd6, 32'hCAFEF00D, 16'hFFFE); put_imm(32'h11223344);
        send("ptr,imm");
        expect_rec("ptr,imm R4 R6", 4'h0, 4'h0, 0, 0, 32'h11223344, 0,
                   4'd5, 4'd6, 32'hCAFEF00D, 16'hFFFE, 4'd12);
        pop();
    endtask

    task automatic t_ptr_reg_direct();
        clr(); put(8'h10); put_ptr(4'd1, 4'd9, 32'h00010203, 16'h0004); put(8'hEC);
        send("ptr,reg");
        expect_rec("ptr,reg direct R6", 4'h0, 4'h1, 4'hC, 0, 0, 0,
                   4'd1, 4'd0, 32'h00010203, 16'h0004, 4'd9);
        pop();
    endtask

    task automatic t_reg_ptr();
        clr(); put(8'h3C); put(8'h02); put_ptr(4'd2, 4'd4, 32'h00000440, 16'h0010);
        send("reg,ptr");
        expect_rec("reg,ptr R4", 4'hC, 4'h3, 4'h2, 0, 0, 0,
                   4'd2, 4'd0, 32'h00000440, 16'h0010, 4'd9);
        pop();
    endtask

    task automatic t_bad_pair();
        push(8'h4B);
        chk("R3 bad pulse", 32'(bad_valid), 32'd1);
        chk("R3 bad_len", 32'(bad_len), 32'd1);
        chk("R3 no record", 32'(out_valid), 32'd0);
        @(posedge clk); #1;
        chk("R3 pulse single", 32'(bad_valid), 32'd0);
        push(8'h0E);
        chk("R3 bad opcode E", 32'(bad_valid), 32'd1);
        clr(); put(8'h6D); put_imm(32'h00000021);
        send("after bad");
        expect_rec("R3 resync", 4'hD, 4'h6, 0, 0, 32'h00000021, 0, 0, 0, 0, 0, 4'd5);
        pop();
    endtask

    task automatic t_bad_ptr();
        clr(); put(8'h00); put_ptr(4'd7, 4'd3, 32'h0, 16'h0); put_imm(32'h0);
        for (int i = 0; i < ilen; i++) begin
            push(ib[i]);
            if (i < ilen - 1) chk("R5 no early pulse", 32'(bad_valid), 32'd0);
        end
        chk("R5 bad pulse", 32'(bad_valid), 32'd1);
        chk("R5 bad_len", 32'(bad_len), 32'd12);
        chk("R5 no record", 32'(out_valid), 32'd0);
        @(posedge clk); #1;
        chk("R5 still no record", 32'(out_valid), 32'd0);
        chk("R5 ready again", 32'(in_ready), 32'd1);
    endtask

    task automatic t_backpressure();
        clr(); put(8'h42); put(8'h01); put(8'h0F);
        send("hold");
        for (int c = 0; c < 3; c++) begin
            chk("R10 held valid", 32'(out_valid), 32'd1);
            chk("R10 in_ready low", 32'(in_ready), 32'd0);
            chk("R10 held reg_b", 32'(out_reg_b), 32'hF);
            @(posedge clk); #1;
        end
        pop();
        chk("R10 released", 32'(out_valid), 32'd0);
        chk("R10 ready after take", 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_reg_reg();
        t_reg_imm();
        t_imm_imm();
        t_imm_only();
        t_ptr_imm();
        t_ptr_reg_direct();
        t_reg_ptr();
        t_bad_pair();
        t_bad_ptr();
        t_backpressure();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule